// File: doc/BRIEF.md
# Priority Interrupt Selector with Acknowledge

This block serves one CPU. Each cycle it receives four vectors from the distributor: enable, pending, target and priority. It finds the interrupt line with the best priority among lines that are enabled, pending and targeted at this CPU. A lower priority value means a more urgent line. The block raises the CPU's interrupt request when that line is more urgent than both the CPU's priority mask and the priority of the interrupt the CPU is already servicing.

The search is sequential. It checks `LANES` lines per clock and takes `ceil(NUM_LINES/LANES)` cycles for a full pass. When a pass ends it starts the next one straight away. The request output and the pending ID change only at the end of a pass, so the compare logic in one clock covers `LANES` lines, never all of them.

The CPU side has four operations: an acknowledge read, an end-of-interrupt write, a priority mask write, and observation of the running state. An accepted acknowledge gives a pulse that tells the distributor to clear the line's pending bit and set its active bit. An accepted end-of-interrupt gives a pulse that tells it to clear the active bit.

Top module: `prio_irq_sel`

## Requirements
- R1: A line is a candidate only if `line_en_i`, `line_pend_i` and `line_tgt_i` are all 1 for it and its index is below `NUM_LINES`. Line `i` takes its priority from `line_prio_i[i*PRIO_W +: PRIO_W]`. The candidate with the numerically lowest priority is selected.
- R2: When candidates share the lowest priority value, the lowest line number is selected. The search starts from value 2^PRIO_W (256) and ID 1023, and replaces the best only on a strictly lower value.
- R3: `irq_o` is 1 and `ack_id_o` shows the selected line only if the selected priority is strictly below both the priority mask and the running priority. Otherwise `irq_o` is 0 and `ack_id_o` is 1023.
- R4: An acknowledge (`ack_i`) while `irq_o` is 1 returns the line ID on `ack_id_o` and pulses `take_o` in the same cycle. At the next edge the running ID and running priority take that line's ID and priority, and `irq_o` drops.
- R5: An acknowledge while `irq_o` is 0 returns 1023. `take_o` stays 0 and the running state does not change.
- R6: An end-of-interrupt (`eoi_i`) whose `eoi_id_i` is below `NUM_LINES` pulses `done_o` in the same cycle. At the next edge the running priority becomes 256 and the running ID becomes 1023.
- R7: An end-of-interrupt whose ID is `NUM_LINES` or more, including 1023, is ignored: `done_o` stays 0 and the running state does not change.
- R8: An accepted acknowledge, an accepted end-of-interrupt or a mask write at clock edge t clears the request and restarts the search. The new result appears at edge t + ceil(NUM_LINES/LANES), and `irq_o` stays 0 in between.
- R9: When an accepted acknowledge and an accepted end-of-interrupt fall in the same cycle, both pulses are given. The running state takes the acknowledged line, not the idle value.
- R10: After reset, `irq_o` is 0, `ack_id_o` is 1023, the running priority is 256, the running ID is 1023 and the priority mask is 0, so no line is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_en_i | input | NUM_LINES | Per-line enable from distributor |
| line_pend_i | input | NUM_LINES | Per-line pending from distributor |
| line_tgt_i | input | NUM_LINES | Per-line target bit for this CPU |
| line_prio_i | input | NUM_LINES*PRIO_W | Per-line priority, line i at bits i*PRIO_W |
| mask_we_i | input | 1 | Priority mask write strobe |
| mask_i | input | PRIO_W | Priority mask write data |
| ack_i | input | 1 | Acknowledge read strobe |
| ack_id_o | output | ID_W | Acknowledge read data (1023 if none) |
| take_o | output | 1 | Acknowledge accepted: clear pending, set active |
| eoi_i | input | 1 | End-of-interrupt write strobe |
| eoi_id_i | input | ID_W | End-of-interrupt line ID |
| done_o | output | 1 | End-of-interrupt accepted: clear active |
| irq_o | output | 1 | Interrupt request to the CPU |
| run_prio_o | output | PRIO_W+1 | Running priority (256 when idle) |
| run_id_o | output | ID_W | Running interrupt ID (1023 when idle) |

## Verification
Two pairs of events can land in the same cycle. The first pair is an acknowledge and an end-of-interrupt. The bench sets up a preemption: one line is running and a more urgent line is pending. It then raises `ack_i` and `eoi_i` together, naming the running line in the end-of-interrupt. The result passes if both pulses appear and the running priority takes the new line's value rather than 256.

The second pair is a search restart and a search completion. The bench writes the mask and then counts edges. It judges the case by `irq_o` staying low for exactly one pass and rising at the final edge of that pass.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned ID_W = 10;
  localparam logic [ID_W-1:0] SPUR_ID = 10'd1023;
  localparam int unsigned MAX_LINES = 1020;
endpackage

// File: rtl/prio_irq_lane_pick.sv
module prio_irq_lane_pick #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned PRIO_W = 8,
  localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0]        cand_i,
  input  logic [LANES*PRIO_W-1:0] prio_i,
  output logic [PRIO_W:0]         best_prio_o,
  output logic [LANE_W-1:0]       best_lane_o
);
  localparam logic [PRIO_W:0] SENT = {1'b1, {PRIO_W{1'b0}}};

  // strict less-than: earlier lane keeps a tie
  always_comb begin
    best_prio_o = SENT;
    best_lane_o = '0;
    for (int l = 0; l < LANES; l++) begin
      if (cand_i[l] && ({1'b0, prio_i[l*PRIO_W +: PRIO_W]} < best_prio_o)) begin
        best_prio_o = {1'b0, prio_i[l*PRIO_W +: PRIO_W]};
        best_lane_o = LANE_W'(l);
      end
    end
  end
endmodule

// File: rtl/prio_irq_scan.sv
module prio_irq_scan
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 96,
  parameter int unsigned LANES     = 8,
  parameter int unsigned PRIO_W    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        restart_i,
  input  logic [NUM_LINES-1:0]        cand_i,
  input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
  output logic                        done_o,
  output logic [PRIO_W:0]             best_prio_o,
  output logic [ID_W-1:0]             best_id_o
);
  localparam int unsigned N_CHUNK = (NUM_LINES + LANES - 1) / LANES;
  localparam int unsigned PAD     = N_CHUNK * LANES;
  localparam int unsigned CH_W    = (N_CHUNK > 1) ? $clog2(N_CHUNK) : 1;
  localparam int unsigned LANE_W  = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [PRIO_W:0] SENT = {1'b1, {PRIO_W{1'b0}}};

  logic [PAD-1:0]        cand_pad;
  logic [PAD*PRIO_W-1:0] prio_pad;

  generate
    if (PAD > NUM_LINES) begin : g_pad
      assign cand_pad = {{(PAD-NUM_LINES){1'b0}}, cand_i};
      assign prio_pad = {{((PAD-NUM_LINES)*PRIO_W){1'b0}}, prio_i};
    end else begin : g_nopad
      assign cand_pad = cand_i;
      assign prio_pad = prio_i;
    end
  endgenerate

  logic [CH_W-1:0]   chunk_q;
  logic [PRIO_W:0]   acc_prio_q;
  logic [ID_W-1:0]   acc_id_q;
  logic [PRIO_W:0]   pick_prio;
  logic [LANE_W-1:0] pick_lane;
  logic [ID_W-1:0]   pick_id;
  logic              last;

  prio_irq_lane_pick #(.LANES(LANES), .PRIO_W(PRIO_W)) u_pick (
    .cand_i      (cand_pad[chunk_q*LANES +: LANES]),
    .prio_i      (prio_pad[chunk_q*LANES*PRIO_W +: LANES*PRIO_W]),
    .best_prio_o (pick_prio),
    .best_lane_o (pick_lane)
  );

  assign pick_id = ID_W'(int'(chunk_q) * LANES + int'(pick_lane));
  assign last    = (chunk_q == CH_W'(N_CHUNK - 1));

  // earlier chunks hold lower line numbers, so the accumulator keeps ties
  always_comb begin
    if (pick_prio < acc_prio_q) begin
      best_prio_o = pick_prio;
      best_id_o   = pick_id;
    end else begin
      best_prio_o = acc_prio_q;
      best_id_o   = acc_id_q;
    end
  end

  assign done_o = last && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chunk_q    <= '0;
      acc_prio_q <= SENT;
      acc_id_q   <= SPUR_ID;
    end else if (restart_i || last) begin
      chunk_q    <= '0;
      acc_prio_q <= SENT;
      acc_id_q   <= SPUR_ID;
    end else begin
      chunk_q    <= chunk_q + 1'b1;
      acc_prio_q <= best_prio_o;
      acc_id_q   <= best_id_o;
    end
  end

  assert_chunk_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(chunk_q) < N_CHUNK);

  assert_acc_monotone_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !last) |=> (acc_prio_q <= $past(acc_prio_q)));
endmodule

// File: rtl/prio_irq_cpu_if.sv
module prio_irq_cpu_if
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 96,
  parameter int unsigned PRIO_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scan_done_i,
  input  logic [PRIO_W:0]   scan_prio_i,
  input  logic [ID_W-1:0]   scan_id_i,
  input  logic              mask_we_i,
  input  logic [PRIO_W-1:0] mask_i,
  input  logic              ack_i,
  input  logic              eoi_i,
  input  logic [ID_W-1:0]   eoi_id_i,
  output logic              restart_o,
  output logic [ID_W-1:0]   ack_id_o,
  output logic              take_o,
  output logic              done_o,
  output logic              irq_o,
  output logic [PRIO_W:0]   run_prio_o,
  output logic [ID_W-1:0]   run_id_o
);
  localparam logic [PRIO_W:0] SENT = {1'b1, {PRIO_W{1'b0}}};

  logic [PRIO_W-1:0] mask_q;
  logic [PRIO_W:0]   run_prio_q;
  logic [ID_W-1:0]   run_id_q;
  logic [PRIO_W:0]   cur_prio_q;
  logic [ID_W-1:0]   cur_id_q;
  logic              cur_vld_q;
  logic              take, eoi_ok, pass;

  assign take      = ack_i && cur_vld_q;
  assign eoi_ok    = eoi_i && (int'(eoi_id_i) < NUM_LINES);
  assign restart_o = take || eoi_ok || mask_we_i;
  assign pass      = (scan_prio_i < {1'b0, mask_q}) && (scan_prio_i < run_prio_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_vld_q  <= 1'b0;
      cur_id_q   <= SPUR_ID;
      cur_prio_q <= SENT;
    end else if (restart_o) begin
      cur_vld_q  <= 1'b0;
      cur_id_q   <= SPUR_ID;
      cur_prio_q <= SENT;
    end else if (scan_done_i) begin
      cur_vld_q  <= pass;
      cur_id_q   <= pass ? scan_id_i : SPUR_ID;
      cur_prio_q <= pass ? scan_prio_i : SENT;
    end
  end

  // acknowledge wins the running state over a same-cycle completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_prio_q <= SENT;
      run_id_q   <= SPUR_ID;
    end else if (take) begin
      run_prio_q <= cur_prio_q;
      run_id_q   <= cur_id_q;
    end else if (eoi_ok) begin
      run_prio_q <= SENT;
      run_id_q   <= SPUR_ID;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_i;
  end

  assign ack_id_o   = cur_id_q;
  assign take_o     = take;
  assign done_o     = eoi_ok;
  assign irq_o      = cur_vld_q;
  assign run_prio_o = run_prio_q;
  assign run_id_o   = run_id_q;

  assert_irq_below_run_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cur_prio_q < run_prio_q) && (cur_prio_q < {1'b0, mask_q}));

  assert_ack_drops_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> !irq_o);

  assert_spur_ack_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && !eoi_i) |=> ($stable(run_prio_q) && $stable(run_id_q)));

  assert_eoi_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_ok && !take) |=> (run_prio_q == SENT) && (run_id_q == SPUR_ID));

  assert_eoi_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && (int'(eoi_id_i) >= NUM_LINES) && !ack_i) |=> ($stable(run_prio_q) && !$past(done_o)));

  assert_ack_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && eoi_ok) |=> (run_prio_q == $past(cur_prio_q)) && (run_prio_q != SENT));
endmodule

// File: rtl/prio_irq_sel.sv
module prio_irq_sel
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 96,
  parameter int unsigned LANES     = 8,
  parameter int unsigned PRIO_W    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_LINES-1:0]        line_en_i,
  input  logic [NUM_LINES-1:0]        line_pend_i,
  input  logic [NUM_LINES-1:0]        line_tgt_i,
  input  logic [NUM_LINES*PRIO_W-1:0] line_prio_i,
  input  logic                        mask_we_i,
  input  logic [PRIO_W-1:0]           mask_i,
  input  logic                        ack_i,
  output logic [ID_W-1:0]             ack_id_o,
  output logic                        take_o,
  input  logic                        eoi_i,
  input  logic [ID_W-1:0]             eoi_id_i,
  output logic                        done_o,
  output logic                        irq_o,
  output logic [PRIO_W:0]             run_prio_o,
  output logic [ID_W-1:0]             run_id_o
);
  logic [NUM_LINES-1:0] cand;
  logic                 restart, scan_done;
  logic [PRIO_W:0]      scan_prio;
  logic [ID_W-1:0]      scan_id;

  assign cand = line_en_i & line_pend_i & line_tgt_i;

  prio_irq_scan #(.NUM_LINES(NUM_LINES), .LANES(LANES), .PRIO_W(PRIO_W)) u_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (restart),
    .cand_i      (cand),
    .prio_i      (line_prio_i),
    .done_o      (scan_done),
    .best_prio_o (scan_prio),
    .best_id_o   (scan_id)
  );

  prio_irq_cpu_if #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_cpu (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scan_done_i (scan_done),
    .scan_prio_i (scan_prio),
    .scan_id_i   (scan_id),
    .mask_we_i   (mask_we_i),
    .mask_i      (mask_i),
    .ack_i       (ack_i),
    .eoi_i       (eoi_i),
    .eoi_id_i    (eoi_id_i),
    .restart_o   (restart),
    .ack_id_o    (ack_id_o),
    .take_o      (take_o),
    .done_o      (done_o),
    .irq_o       (irq_o),
    .run_prio_o  (run_prio_o),
    .run_id_o    (run_id_o)
  );

  assert_spur_no_take_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (ack_id_o != SPUR_ID) && (int'(ack_id_o) < NUM_LINES));
endmodule

// File: tb/sim_prio_irq_sel.sv
`timescale 1ns/1ps
module sim_prio_irq_sel;
  localparam int NL  = 96;
  localparam int LN  = 8;
  localparam int PW  = 8;
  localparam int NCH = (NL + LN - 1) / LN;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NL-1:0]   line_en_i, line_pend_i, line_tgt_i;
  logic [NL*PW-1:0] line_prio_i;
  logic            mask_we_i = 1'b0;
  logic [PW-1:0]   mask_i = '0;
  logic            ack_i = 1'b0;
  logic [9:0]      ack_id_o;
  logic            take_o;
  logic            eoi_i = 1'b0;
  logic [9:0]      eoi_id_i = '0;
  logic            done_o, irq_o;
  logic [PW:0]     run_prio_o;
  logic [9:0]      run_id_o;

  int n_cmp = 0;
  int n_bad = 0;
  int mdl_mask = 0;
  int mdl_run = 256;
  int exp_q[$];
  string req_q[$];

  always #2 clk_i = ~clk_i;

  prio_irq_sel #(.NUM_LINES(NL), .LANES(LN), .PRIO_W(PW)) u0 (.*);

  task automatic chk(string r, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  function automatic int ref_id();
    int bp = 256;
    int bi = 1023;
    for (int i = 0; i < NL; i++)
      if (line_en_i[i] && line_pend_i[i] && line_tgt_i[i] && int'(line_prio_i[i*PW +: PW]) < bp) begin
        bp = int'(line_prio_i[i*PW +: PW]);
        bi = i;
      end
    if (bp < mdl_mask && bp < mdl_run) return bi;
    return 1023;
  endfunction

  task automatic set_line(int i, bit p, int pr);
    line_pend_i[i] = p;
    line_prio_i[i*PW +: PW] = PW'(pr);
  endtask

  task automatic settle();
    repeat (2*NCH + 2) @(posedge clk_i);
  endtask

  task automatic do_ack(string r);
    int e;
    @(negedge clk_i);
    e = ref_id();
    exp_q.push_back(e);
    req_q.push_back(r);
    ack_i = 1'b1;
    #1 chk({r, " take"}, int'(take_o), int'(e != 1023));
    @(posedge clk_i);
    #1 ack_i = 1'b0;
    if (e != 1023) begin
      line_pend_i[e] = 1'b0;
      mdl_run = int'(line_prio_i[e*PW +: PW]);
    end
  endtask

  task automatic do_eoi(string r, int id);
    @(negedge clk_i);
    eoi_i = 1'b1;
    eoi_id_i = 10'(id);
    #1 chk({r, " done"}, int'(done_o), int'(id < NL));
    @(posedge clk_i);
    #1 eoi_i = 1'b0;
    if (id < NL) mdl_run = 256;
  endtask

  task automatic do_mask(int m);
    @(negedge clk_i);
    mask_we_i = 1'b1;
    mask_i = PW'(m);
    @(posedge clk_i);
    #1 mask_we_i = 1'b0;
    mdl_mask = m;
  endtask

  task automatic do_ack_eoi(int id);
    int e;
    @(negedge clk_i);
    e = ref_id();
    exp_q.push_back(e);
    req_q.push_back("R9");
    ack_i = 1'b1;
    eoi_i = 1'b1;
    eoi_id_i = 10'(id);
    #1;
    chk("R9 take", int'(take_o), 1);
    chk("R9 done", int'(done_o), 1);
    @(posedge clk_i);
    #1 ack_i = 1'b0;
    eoi_i = 1'b0;
    if (e != 1023) begin
      line_pend_i[e] = 1'b0;
      mdl_run = int'(line_prio_i[e*PW +: PW]);
    end
  endtask

  // scoreboard monitor: compares acknowledge data as the design returns it
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (ack_i) begin
        if (exp_q.size() == 0) chk("scoreboard underflow", 1, 0);
        else chk({req_q.pop_front(), " ack id"}, int'(ack_id_o), exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    line_en_i = '1;
    line_tgt_i = '1;
    line_pend_i = '0;
    for (int i = 0; i < NL; i++) line_prio_i[i*PW +: PW] = 8'h80;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    #1;
    chk("R10 irq", int'(irq_o), 0);
    chk("R10 ack id", int'(ack_id_o), 1023);
    chk("R10 run prio", int'(run_prio_o), 256);
    chk("R10 run id", int'(run_id_o), 1023);

    set_line(5, 1, 8'h40);
    set_line(70, 1, 8'h20);
    settle();
    #1 chk("R3 mask zero blocks", int'(irq_o), 0);

    // R8: restart at mask write, result after exactly one pass
    do_mask(8'hFF);
    for (int k = 1; k < NCH; k++) begin
      @(posedge clk_i);
      #1 chk("R8 irq held low", int'(irq_o), 0);
    end
    @(posedge clk_i);
    #1 chk("R8 irq at pass end", int'(irq_o), 1);

    do_ack("R1 R4");
    #1;
    chk("R4 run prio", int'(run_prio_o), 8'h20);
    chk("R4 run id", int'(run_id_o), 70);
    chk("R4 irq drops", int'(irq_o), 0);
    settle();
    #1 chk("R3 below running", int'(irq_o), 0);
    do_ack("R5");
    #1 chk("R5 run prio kept", int'(run_prio_o), 8'h20);

    do_eoi("R7", 1023);
    do_eoi("R7", 200);
    do_eoi("R7", NL);
    #1 chk("R7 run prio kept", int'(run_prio_o), 8'h20);
    do_eoi("R6", 70);
    #1;
    chk("R6 run prio idle", int'(run_prio_o), 256);
    chk("R6 run id idle", int'(run_id_o), 1023);
    settle();
    do_ack("R1");
    do_eoi("R6", 5);

    // ties and filtered lines
    set_line(10, 1, 8'h30);
    set_line(40, 1, 8'h30);
    set_line(90, 1, 8'h30);
    set_line(3, 1, 8'h00);
    line_en_i[3] = 1'b0;
    set_line(4, 1, 8'h00);
    line_tgt_i[4] = 1'b0;
    settle();
    do_ack("R2");
    do_eoi("R6", 10);
    settle();
    do_ack("R2");
    do_eoi("R6", 40);
    settle();
    do_ack("R2");
    do_eoi("R6", 90);

    // last line and mask boundary
    set_line(95, 1, 8'h01);
    set_line(0, 1, 8'h02);
    settle();
    do_ack("R1 last line");
    do_eoi("R6", 95);
    do_mask(8'h02);
    settle();
    #1 chk("R3 equal mask", int'(irq_o), 0);
    do_ack("R3");
    do_mask(8'h03);
    settle();
    do_ack("R3");
    do_eoi("R6", 0);
    do_mask(8'hFF);

    // ack and eoi in the same cycle
    set_line(20, 1, 8'h60);
    settle();
    do_ack("R4");
    set_line(30, 1, 8'h10);
    settle();
    #1 chk("R3 preempt irq", int'(irq_o), 1);
    do_ack_eoi(20);
    #1;
    chk("R9 run prio", int'(run_prio_o), 8'h10);
    chk("R9 run id", int'(run_id_o), 30);
    do_eoi("R6", 30);
    settle();
    #1;
    chk("R1 filtered lines stay quiet", int'(irq_o), 0);
    chk("R6 final run prio", int'(run_prio_o), 256);
    chk("scoreboard drained", exp_q.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule